// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block decides when a small processor core may leave reset and records what caused the most recent reset or wake-up. A power-on pulse or an enabled brown-out level starts a cold start. The cold start runs a power-up delay, then an oscillator settling delay, or only one of them, depending on the oscillator mode and the power-up timer disable input. Wake-ups from sleep insert only the oscillator settling delay, and only in crystal-type modes.

Each cause leaves a fixed pattern in four sticky flags: power-on, brown-out, time-out and power-down. The same cause also selects where the core starts executing. Software may rewrite the power-on and brown-out flags. The external reset pin always holds the core while it is low, but it never stops the delays, so a pin released after they expire lets the core run at once.

Both delays are counted in clock cycles. The power-up delay is `CYC_PER_MS * PWRT_MS` cycles, called T_PW below. The oscillator delay is `OST_CYCLES` cycles, called T_OS below.

Top module: `rstseq_top`

## Requirements
- R1: After `rst_n` the block waits for a cold start. `core_hold_o`=1, `pwr_flags_o`=00, `tp_flags_o`=11 and `vec_sel_o`=0. Here `pwr_flags_o`={power-on flag, brown-out flag}, `tp_flags_o`={time-out flag, power-down flag}, and `vec_sel_o` is 0 for the reset vector, 1 for the next instruction and 2 for the interrupt vector.
- R2: After a power-on pulse, `core_hold_o` stays high for a number of cycles that depends on the mode:
  - crystal mode, timer enabled: T_PW+T_OS
  - crystal mode, `pwrt_dis_i`=1: T_OS
  - RC mode (`osc_rc_i`=1), timer enabled: T_PW
  - RC mode, timer disabled: one cycle
- R3: A power-on pulse sets `pwr_flags_o[1]`=0, leaves `pwr_flags_o[0]` unchanged, sets `tp_flags_o`=11 and sets `vec_sel_o`=0.
- R4: A brown-out level with `bod_en_i`=1 sets `pwr_flags_o[0]`=0, leaves `pwr_flags_o[1]` unchanged, sets `tp_flags_o`=11 and `vec_sel_o`=0, and uses the R2 delays. While the level stays high it restarts the delays, so the full delay counts from its last high cycle.
- R5: With `bod_en_i`=0 the brown-out input has no effect on the hold or on any flag.
- R6: A low external pin holds the core, but the delays keep counting. If the pin is released after the delays have expired, `core_hold_o` falls in the same cycle.
- R7: A low external pin while running awake leaves all four flags unchanged and sets `vec_sel_o`=0.
- R8: A low external pin while `sleep_i`=1 sets `tp_flags_o`=10 (time-out 1, power-down 0), leaves `pwr_flags_o` unchanged and sets `vec_sel_o`=0.
- R9: A watchdog time-out while awake sets `tp_flags_o`=01 and `vec_sel_o`=0, and holds the core for exactly one cycle.
- R10: A watchdog time-out while asleep sets `tp_flags_o`=00 and `vec_sel_o`=1. It holds the core T_OS cycles in crystal mode and not at all in RC mode.
- R11: An interrupt wake while asleep sets `tp_flags_o`=10 and `vec_sel_o`=1 when `gie_i`=0, or 2 when `gie_i`=1, with the R10 delays. An interrupt wake while awake has no effect.
- R12: A software write (`sw_we_i`=1) loads `sw_flags_i` into `pwr_flags_o` on the next cycle and leaves `tp_flags_o` unchanged. A power-on or enabled brown-out in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_i | input | 1 | Power-on pulse |
| bod_i | input | 1 | Brown-out detect level |
| bod_en_i | input | 1 | Brown-out detection enable |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_to_i | input | 1 | Watchdog time-out event |
| irq_wake_i | input | 1 | Interrupt wake request |
| gie_i | input | 1 | Global interrupt enable of the core |
| sleep_i | input | 1 | Core is in sleep |
| osc_rc_i | input | 1 | 1 = RC oscillator, 0 = crystal-type |
| pwrt_dis_i | input | 1 | 1 = power-up timer disabled |
| sw_we_i | input | 1 | Software write strobe for the flags |
| sw_flags_i | input | 2 | Software value {power-on, brown-out} |
| core_hold_o | output | 1 | Holds the core in reset |
| vec_sel_o | output | 2 | Start vector select |
| pwr_flags_o | output | 2 | {power-on flag, brown-out flag} |
| tp_flags_o | output | 2 | {time-out flag, power-down flag} |

## Verification
The bench builds the block with `CYC_PER_MS`=4, `PWRT_MS`=3 and `OST_CYCLES`=5, so T_PW is 12 cycles and T_OS is 5 cycles. Every cold-start and wake path therefore finishes in a few dozen cycles. This lets the bench sweep both oscillator modes against both timer settings, for both power-on and brown-out, and both modes against every wake kind. It counts the exact hold length for each combination. The short delays also make it cheap to test an extended brown-out level and a pin released after the delays have expired.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    SEQ_WAIT,
    SEQ_PWRT,
    SEQ_OST,
    SEQ_PULSE,
    SEQ_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    VEC_RESET = 2'd0,
    VEC_NEXT  = 2'd1,
    VEC_IRQ   = 2'd2
  } vec_sel_e;

  typedef struct packed {
    logic por;
    logic bod;
    logic pin_run;
    logic pin_sleep;
    logic wdt_rst;
    logic wdt_wake;
    logic irq_wake;
  } cause_t;

endpackage

// File: rtl/rstseq_delay.sv
// Modulo-LIMIT step counter; last_o marks the step that completes a period.
module rstseq_delay #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign last_o = step_i && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d = last_o ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rstseq_cause.sv
// Classifies reset and wake causes; keeps the sticky flags and start vector.
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       bod_i,
  input  logic       bod_en_i,
  input  logic       ext_rst_n_i,
  input  logic       wdt_to_i,
  input  logic       irq_wake_i,
  input  logic       gie_i,
  input  logic       sleep_i,
  input  logic       in_run_i,
  input  logic       sw_we_i,
  input  logic [1:0] sw_flags_i,
  output logic       cold_o,
  output logic       wdt_rst_o,
  output logic       wake_o,
  output logic [1:0] pwr_flags_o,
  output logic [1:0] tp_flags_o,
  output logic [1:0] vec_sel_o
);
  cause_t   ev;
  logic     quiet, live;
  logic     por_q, bor_q, to_q, pd_q;
  logic     por_d, bor_d, to_d, pd_d;
  vec_sel_e vec_q, vec_d;

  always_comb begin
    ev          = '0;
    ev.por      = por_i;
    ev.bod      = bod_i & bod_en_i & ~por_i;
    quiet       = ~ev.por & ~ev.bod & in_run_i;
    ev.pin_run  = quiet & ~ext_rst_n_i & ~sleep_i;
    ev.pin_sleep= quiet & ~ext_rst_n_i & sleep_i;
    live        = quiet & ext_rst_n_i;
    ev.wdt_rst  = live & wdt_to_i & ~sleep_i;
    ev.wdt_wake = live & wdt_to_i & sleep_i;
    ev.irq_wake = live & irq_wake_i & sleep_i & ~wdt_to_i;
  end

  assign cold_o    = ev.por | ev.bod;
  assign wdt_rst_o = ev.wdt_rst;
  assign wake_o    = ev.wdt_wake | ev.irq_wake;

  always_comb begin
    por_d = por_q;
    bor_d = bor_q;
    to_d  = to_q;
    pd_d  = pd_q;
    vec_d = vec_q;
    if (ev.por) begin
      por_d = 1'b0;
      to_d  = 1'b1;
      pd_d  = 1'b1;
      vec_d = VEC_RESET;
    end else if (ev.bod) begin
      bor_d = 1'b0;
      to_d  = 1'b1;
      pd_d  = 1'b1;
      vec_d = VEC_RESET;
    end else begin
      if (sw_we_i) begin
        {por_d, bor_d} = sw_flags_i;
      end
      if (ev.pin_run) begin
        vec_d = VEC_RESET;
      end
      if (ev.pin_sleep) begin
        to_d  = 1'b1;
        pd_d  = 1'b0;
        vec_d = VEC_RESET;
      end
      if (ev.wdt_rst) begin
        to_d  = 1'b0;
        pd_d  = 1'b1;
        vec_d = VEC_RESET;
      end
      if (ev.wdt_wake) begin
        to_d  = 1'b0;
        pd_d  = 1'b0;
        vec_d = VEC_NEXT;
      end
      if (ev.irq_wake) begin
        to_d  = 1'b1;
        pd_d  = 1'b0;
        vec_d = gie_i ? VEC_IRQ : VEC_NEXT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b0;
      bor_q <= 1'b0;
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
      vec_q <= VEC_RESET;
    end else begin
      por_q <= por_d;
      bor_q <= bor_d;
      to_q  <= to_d;
      pd_q  <= pd_d;
      vec_q <= vec_d;
    end
  end

  assign pwr_flags_o = {por_q, bor_q};
  assign tp_flags_o  = {to_q, pd_q};
  assign vec_sel_o   = vec_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 20000,
  parameter int unsigned PWRT_MS    = 72,
  parameter int unsigned OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       bod_i,
  input  logic       bod_en_i,
  input  logic       ext_rst_n_i,
  input  logic       wdt_to_i,
  input  logic       irq_wake_i,
  input  logic       gie_i,
  input  logic       sleep_i,
  input  logic       osc_rc_i,
  input  logic       pwrt_dis_i,
  input  logic       sw_we_i,
  input  logic [1:0] sw_flags_i,
  output logic       core_hold_o,
  output logic [1:0] vec_sel_o,
  output logic [1:0] pwr_flags_o,
  output logic [1:0] tp_flags_o
);
  seq_state_e st_q, st_d;
  logic       cold, wdt_rst, wake, clr;
  logic       ms_tick, pwrt_last, ost_last;

  rstseq_cause u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_i       (por_i),
    .bod_i       (bod_i),
    .bod_en_i    (bod_en_i),
    .ext_rst_n_i (ext_rst_n_i),
    .wdt_to_i    (wdt_to_i),
    .irq_wake_i  (irq_wake_i),
    .gie_i       (gie_i),
    .sleep_i     (sleep_i),
    .in_run_i    (st_q == SEQ_RUN),
    .sw_we_i     (sw_we_i),
    .sw_flags_i  (sw_flags_i),
    .cold_o      (cold),
    .wdt_rst_o   (wdt_rst),
    .wake_o      (wake),
    .pwr_flags_o (pwr_flags_o),
    .tp_flags_o  (tp_flags_o),
    .vec_sel_o   (vec_sel_o)
  );

  // Millisecond prescaler, then millisecond count of the power-up delay.
  rstseq_delay #(.LIMIT(CYC_PER_MS)) u_presc (
    .clk (clk), .rst_n (rst_n), .clr_i (clr),
    .step_i (st_q == SEQ_PWRT), .last_o (ms_tick)
  );

  rstseq_delay #(.LIMIT(PWRT_MS)) u_pwrt (
    .clk (clk), .rst_n (rst_n), .clr_i (clr),
    .step_i (ms_tick), .last_o (pwrt_last)
  );

  rstseq_delay #(.LIMIT(OST_CYCLES)) u_ost (
    .clk (clk), .rst_n (rst_n), .clr_i (clr),
    .step_i (st_q == SEQ_OST), .last_o (ost_last)
  );

  always_comb begin
    st_d = st_q;
    clr  = 1'b0;
    if (cold) begin
      clr  = 1'b1;
      st_d = !pwrt_dis_i ? SEQ_PWRT : (osc_rc_i ? SEQ_PULSE : SEQ_OST);
    end else if (wdt_rst) begin
      clr  = 1'b1;
      st_d = SEQ_PULSE;
    end else if (wake) begin
      clr  = 1'b1;
      st_d = osc_rc_i ? SEQ_RUN : SEQ_OST;
    end else begin
      unique case (st_q)
        SEQ_PWRT:  if (pwrt_last) st_d = osc_rc_i ? SEQ_RUN : SEQ_OST;
        SEQ_OST:   if (ost_last) st_d = SEQ_RUN;
        SEQ_PULSE: st_d = SEQ_RUN;
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_WAIT;
    end else begin
      st_q <= st_d;
    end
  end

  assign core_hold_o = (st_q != SEQ_RUN) || !ext_rst_n_i;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_i,
  input logic       bod_i,
  input logic       bod_en_i,
  input logic       ext_rst_n_i,
  input logic       sw_we_i,
  input logic [1:0] sw_flags_i,
  input logic       core_hold_o,
  input logic [1:0] vec_sel_o,
  input logic [1:0] pwr_flags_o,
  input logic [1:0] tp_flags_o
);
  assert_por_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> core_hold_o);

  assert_por_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (!pwr_flags_o[1] && tp_flags_o == 2'b11 && vec_sel_o == 2'd0));

  assert_bod_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bod_i && bod_en_i && !por_i) |=>
      (!pwr_flags_o[0] && tp_flags_o == 2'b11 && core_hold_o
       && pwr_flags_o[1] == $past(pwr_flags_o[1])));

  assert_pin_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n_i |-> core_hold_o);

  assert_sw_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we_i && !por_i && !(bod_i && bod_en_i)) |=>
      (pwr_flags_o == $past(sw_flags_i) && $stable(tp_flags_o)));

  assert_vec_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_sel_o != 2'd3);
endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_i       (por_i),
  .bod_i       (bod_i),
  .bod_en_i    (bod_en_i),
  .ext_rst_n_i (ext_rst_n_i),
  .sw_we_i     (sw_we_i),
  .sw_flags_i  (sw_flags_i),
  .core_hold_o (core_hold_o),
  .vec_sel_o   (vec_sel_o),
  .pwr_flags_o (pwr_flags_o),
  .tp_flags_o  (tp_flags_o)
);

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 4;
  localparam int PMS = 3;
  localparam int OSC = 5;
  localparam int TPW = CPM * PMS;

  logic clk = 1'b0;
  logic rst_n;
  logic por_i, bod_i, bod_en_i, ext_rst_n_i, wdt_to_i, irq_wake_i;
  logic gie_i, sleep_i, osc_rc_i, pwrt_dis_i, sw_we_i;
  logic [1:0] sw_flags_i;
  logic core_hold_o;
  logic [1:0] vec_sel_o, pwr_flags_o, tp_flags_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstseq_top #(.CYC_PER_MS(CPM), .PWRT_MS(PMS), .OST_CYCLES(OSC)) uut (
    .clk (clk), .rst_n (rst_n), .por_i (por_i), .bod_i (bod_i),
    .bod_en_i (bod_en_i), .ext_rst_n_i (ext_rst_n_i), .wdt_to_i (wdt_to_i),
    .irq_wake_i (irq_wake_i), .gie_i (gie_i), .sleep_i (sleep_i),
    .osc_rc_i (osc_rc_i), .pwrt_dis_i (pwrt_dis_i), .sw_we_i (sw_we_i),
    .sw_flags_i (sw_flags_i), .core_hold_o (core_hold_o),
    .vec_sel_o (vec_sel_o), .pwr_flags_o (pwr_flags_o), .tp_flags_o (tp_flags_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // which: 0 power-on, 1 brown-out, 2 watchdog, 3 interrupt wake
  task automatic fire(input int which);
    case (which)
      0: por_i = 1'b1;
      1: bod_i = 1'b1;
      2: wdt_to_i = 1'b1;
      default: irq_wake_i = 1'b1;
    endcase
    tick();
    por_i = 1'b0; bod_i = 1'b0; wdt_to_i = 1'b0; irq_wake_i = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (core_hold_o && n < 1000) begin
      n++;
      tick();
    end
  endtask

  task automatic sw_write(input logic [1:0] v);
    sw_we_i = 1'b1; sw_flags_i = v;
    tick();
    sw_we_i = 1'b0;
  endtask

  function automatic int cold_len(input int rc, input int dis);
    if (rc == 0) return (dis == 0) ? TPW + OSC : OSC;
    return (dis == 0) ? TPW : 1;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    por_i = 0; bod_i = 0; bod_en_i = 1; ext_rst_n_i = 1; wdt_to_i = 0;
    irq_wake_i = 0; gie_i = 0; sleep_i = 0; osc_rc_i = 0; pwrt_dis_i = 0;
    sw_we_i = 0; sw_flags_i = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state, waits for a cold start
    chk("R1 hold", core_hold_o, 1);
    chk("R1 pwr", pwr_flags_o, 0);
    chk("R1 tp", tp_flags_o, 3);
    chk("R1 vec", vec_sel_o, 0);
    repeat (4) tick();
    chk("R1 hold waits", core_hold_o, 1);

    // R2/R3/R4: cold starts over every mode and timer setting
    for (int src = 0; src < 2; src++) begin
      for (int rc = 0; rc < 2; rc++) begin
        for (int dis = 0; dis < 2; dis++) begin
          sw_write(2'b11);
          chk("R12 write", pwr_flags_o, 3);
          osc_rc_i = rc[0]; pwrt_dis_i = dis[0];
          fire(src);
          measure(n);
          if (src == 0) begin
            chk("R2 power-on hold length", n, cold_len(rc, dis));
            chk("R3 power-on pwr flags", pwr_flags_o, 1);
            chk("R3 power-on tp flags", tp_flags_o, 3);
            chk("R3 power-on vec", vec_sel_o, 0);
          end else begin
            chk("R4 brown-out hold length", n, cold_len(rc, dis));
            chk("R4 brown-out pwr flags", pwr_flags_o, 2);
            chk("R4 brown-out tp flags", tp_flags_o, 3);
            chk("R4 brown-out vec", vec_sel_o, 0);
          end
        end
      end
    end
    osc_rc_i = 0; pwrt_dis_i = 0;

    // R4: an extended brown-out level restarts the delay
    bod_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R4 hold during brown-out", core_hold_o, 1);
    end
    bod_i = 1'b0;
    measure(n);
    chk("R4 restart length", n, TPW + OSC);

    // R5: brown-out ignored when disabled
    sw_write(2'b11);
    bod_en_i = 1'b0;
    bod_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R5 no hold", core_hold_o, 0);
    end
    bod_i = 1'b0;
    chk("R5 pwr unchanged", pwr_flags_o, 3);
    chk("R5 tp unchanged", tp_flags_o, 3);
    bod_en_i = 1'b1;

    // R6: pin held low across a power-on, released after expiry
    ext_rst_n_i = 1'b0;
    fire(0);
    repeat (TPW + OSC + 4) tick();
    chk("R6 held by pin", core_hold_o, 1);
    ext_rst_n_i = 1'b1;
    #1;
    chk("R6 release immediate", core_hold_o, 0);
    tick();

    // R9: watchdog reset while awake
    fire(2);
    measure(n);
    chk("R9 hold length", n, 1);
    chk("R9 tp flags", tp_flags_o, 1);
    chk("R9 vec", vec_sel_o, 0);

    // R10/R11: every wake kind in both modes
    for (int rc = 0; rc < 2; rc++) begin
      for (int kind = 0; kind < 3; kind++) begin
        fire(2);
        measure(n);
        osc_rc_i = rc[0];
        sleep_i = 1'b1;
        gie_i = (kind == 2);
        fire(kind == 0 ? 2 : 3);
        measure(n);
        sleep_i = 1'b0;
        if (kind == 0) begin
          chk("R10 wake hold", n, rc ? 0 : OSC);
          chk("R10 tp flags", tp_flags_o, 0);
          chk("R10 vec", vec_sel_o, 1);
        end else begin
          chk("R11 wake hold", n, rc ? 0 : OSC);
          chk("R11 tp flags", tp_flags_o, 2);
          chk("R11 vec", vec_sel_o, kind == 2 ? 2 : 1);
        end
      end
    end
    osc_rc_i = 0; gie_i = 0;

    // R11: interrupt while awake is ignored
    fire(3);
    chk("R11 awake no hold", core_hold_o, 0);
    chk("R11 awake tp", tp_flags_o, 2);
    chk("R11 awake vec", vec_sel_o, 2);

    // R7: pin low while running awake, after a watchdog wake
    sw_write(2'b10);
    sleep_i = 1'b1;
    fire(2);
    measure(n);
    sleep_i = 1'b0;
    ext_rst_n_i = 1'b0;
    tick(); tick();
    chk("R7 hold", core_hold_o, 1);
    chk("R7 tp unchanged", tp_flags_o, 0);
    chk("R7 pwr unchanged", pwr_flags_o, 2);
    chk("R7 vec", vec_sel_o, 0);
    ext_rst_n_i = 1'b1;
    tick();

    // R8: pin low during sleep, after a watchdog wake
    sleep_i = 1'b1;
    fire(2);
    measure(n);
    ext_rst_n_i = 1'b0;
    tick(); tick();
    chk("R8 hold", core_hold_o, 1);
    chk("R8 tp flags", tp_flags_o, 2);
    chk("R8 pwr unchanged", pwr_flags_o, 2);
    chk("R8 vec", vec_sel_o, 0);
    ext_rst_n_i = 1'b1;
    sleep_i = 1'b0;
    tick();

    // R12: write leaves tp alone; power-on in the same cycle wins
    fire(2);
    measure(n);
    sw_write(2'b01);
    chk("R12 pwr", pwr_flags_o, 1);
    chk("R12 tp unchanged", tp_flags_o, 1);
    sw_write(2'b00);
    sw_we_i = 1'b1; sw_flags_i = 2'b11;
    fire(0);
    sw_we_i = 1'b0;
    chk("R12 power-on wins", pwr_flags_o, 0);
    measure(n);
    chk("R2 after precedence", n, TPW + OSC);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule